// File: doc/BRIEF.md
# Serial double-error-correcting (15,7) block encoder

The block turns one 7-bit character code into a 15-bit systematic codeword of a binary cyclic code that corrects any two bit errors. The generator polynomial is g(x) = 1 + x^4 + x^6 + x^7 + x^8. It is the product of the two minimal polynomials 1 + x + x^4 and 1 + x + x^2 + x^3 + x^4. The codeword is c(x) = x^8·m(x) + b(x), where b(x) is the remainder of x^8·m(x) divided by g(x).

Inside, the message is loaded into a parallel-to-serial register. The message bits enter a division LFSR highest degree first. The eight remainder bits are then shifted out into a serial-to-parallel register.

A full encode takes 15 enabled clock cycles. After them a hold strobe rises and the codeword is presented. The asynchronous active-low reset clears the block and arms it for the next character. The message is captured on the first enabled cycle after reset release. Cycles with enable low freeze the encode.

Top module: `bch15_enc`

## Requirements
- R1: While rst_ni is low, hold_o is 0 and cw_o is all zeros.
- R2: hold_o rises on exactly the 15th rising clock edge after reset release at which en_i is high, and not before.
- R3: Edges with en_i low do not advance the encode, so they delay the rise of hold_o by one edge each.
- R4: When hold_o is high, cw_o[14:8] equals the message m6..m0 and cw_o[7:0] holds the parity b7..b0. The message is msg_i as sampled at the first enabled edge, with msg_i[6] = m6 the coefficient of x^6. b(x) is the remainder of x^8·m(x) mod g(x), with g(x) = 1+x^4+x^6+x^7+x^8.
- R5: Whenever hold_o is high, cw_o read as a polynomial (bit i = coefficient of x^i) is a multiple of g(x).
- R6: Changes of msg_i after the first enabled edge have no effect on the codeword.
- R7: Once high, hold_o stays high, and cw_o stays unchanged whatever en_i and msg_i do, until the next reset.
- R8: While hold_o is low, cw_o is all zeros.
- R9: The all-zero message yields the all-zero codeword with hold_o high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; re-arms the encoder |
| en_i | input | 1 | Advance the encode by one step |
| msg_i | input | 7 | Character code, sampled at the first enabled edge |
| cw_o | output | 15 | Codeword {message, parity}, zero until valid |
| hold_o | output | 1 | Codeword valid, held until reset |

## Verification
The hardest case to reach from the ports is an encode stretched by enable gaps, during which msg_i keeps changing. Only the first enabled sample may reach the codeword, and the hold edge must land on the 15th enabled edge, not the 15th clock. The bench drives random enable gaps and new random msg_i values on every cycle after the capture edge. It sweeps all 128 messages and more random ones this way, and compares each codeword with a polynomial division done in the bench.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;
  localparam int unsigned MSG_W = 7;
  localparam int unsigned PAR_W = 8;
  localparam int unsigned CW_W  = MSG_W + PAR_W;
  // g(x) = 1 + x^4 + x^6 + x^7 + x^8, bit i = coefficient of x^i
  localparam logic [PAR_W:0] GEN_POLY = 9'h1D1;
endpackage

// File: rtl/bch_msg_ser.sv
module bch_msg_ser #(
  parameter int unsigned W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [W-1:0] msg_i,
  output logic [W-1:0] msg_o,
  output logic         bit_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      msg_o <= '0;
    end else if (load_i) begin
      msg_o <= msg_i;
      sr_q  <= {msg_i[W-2:0], 1'b0};  // msb consumed directly on load edge
    end else if (shift_i) begin
      sr_q  <= {sr_q[W-2:0], 1'b0};
    end
  end

  assign bit_o = sr_q[W-1];
endmodule

// File: rtl/bch_lfsr_div.sv
module bch_lfsr_div #(
  parameter int unsigned       PW  = 8,
  parameter logic [PW:0]       GEN = 9'h1D1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic div_i,
  input  logic shift_i,
  input  logic bit_i,
  output logic msb_o
);
  logic [PW-1:0] rem_q;
  logic          fb;

  assign fb = bit_i ^ rem_q[PW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      rem_q <= '0;
    else if (div_i)
      rem_q <= {rem_q[PW-2:0], 1'b0} ^ ({PW{fb}} & GEN[PW-1:0]);
    else if (shift_i)
      rem_q <= {rem_q[PW-2:0], 1'b0};
  end

  assign msb_o = rem_q[PW-1];
endmodule

// File: rtl/bch_par_des.sv
module bch_par_des #(
  parameter int unsigned PW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [PW-1:0] par_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      par_o <= '0;
    else if (shift_i)
      par_o <= {par_o[PW-2:0], bit_i};
  end
endmodule

// File: rtl/bch15_enc.sv
module bch15_enc
  import bch_enc_pkg::*;
#(
  parameter int unsigned     K   = MSG_W,
  parameter int unsigned     P   = PAR_W,
  parameter logic [P:0]      GEN = GEN_POLY
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [K-1:0]   msg_i,
  output logic [K+P-1:0] cw_o,
  output logic           hold_o
);
  localparam int unsigned N     = K + P;
  localparam int unsigned CNT_W = $clog2(N + 1);
  localparam logic [CNT_W-1:0] CNT_K = CNT_W'(K);
  localparam logic [CNT_W-1:0] CNT_N = CNT_W'(N);

  logic [CNT_W-1:0] cnt_q;
  logic             load, div, pshift, ser_bit, div_bit, rem_bit;
  logic [K-1:0]     msg_q;
  logic [P-1:0]     par_q;

  assign load   = en_i && (cnt_q == '0);
  assign div    = en_i && (cnt_q < CNT_K);
  assign pshift = en_i && (cnt_q >= CNT_K) && (cnt_q < CNT_N);
  assign div_bit = load ? msg_i[K-1] : ser_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      cnt_q <= '0;
    else if (en_i && (cnt_q < CNT_N))
      cnt_q <= cnt_q + 1'b1;
  end

  bch_msg_ser #(.W(K)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(load), .shift_i(div),
    .msg_i(msg_i), .msg_o(msg_q), .bit_o(ser_bit)
  );

  bch_lfsr_div #(.PW(P), .GEN(GEN)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .div_i(div), .shift_i(pshift),
    .bit_i(div_bit), .msb_o(rem_bit)
  );

  bch_par_des #(.PW(P)) u_des (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(pshift),
    .bit_i(rem_bit), .par_o(par_q)
  );

  assign hold_o = (cnt_q == CNT_N);
  assign cw_o   = hold_o ? {msg_q, par_q} : '0;
endmodule

// File: rtl/bch15_enc_chk.sv
module bch15_enc_chk #(
  parameter int unsigned W = 15,
  parameter logic [8:0]  G = 9'h1D1
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         en_i,
  input logic [W-1:0] cw_o,
  input logic         hold_o
);
  function automatic logic [7:0] mod_g(input logic [W-1:0] v);
    logic [W-1:0] r;
    r = v;
    for (int i = W - 1; i >= 8; i--)
      if (r[i]) r = r ^ (W'(G) << (i - 8));
    return r[7:0];
  endfunction

  // R7
  hold_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> hold_o);
  // R7
  cw_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |=> $stable(cw_o));
  // R8
  cw_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hold_o |-> (cw_o == '0));
  // R3
  en_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !hold_o) |=> !hold_o);
  // R5
  cw_multiple_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (mod_g(cw_o) == 8'h00));
endmodule

bind bch15_enc bch15_enc_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cw_o(cw_o), .hold_o(hold_o)
);

// File: tb/sim_bch15_enc.sv
module sim_bch15_enc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic [6:0]  msg_i = '0;
  logic [14:0] cw_o;
  logic        hold_o;
  int checks = 0;
  int failures = 0;

  always #5 clk_i = ~clk_i;

  bch15_enc u0 (.clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .msg_i(msg_i),
                .cw_o(cw_o), .hold_o(hold_o));

  function automatic logic [14:0] ref_cw(input logic [6:0] m);
    logic [14:0] r;
    r = {m, 8'h00};
    for (int i = 14; i >= 8; i--)
      if (r[i]) r = r ^ (15'h1D1 << (i - 8));
    return {m, r[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [14:0] act,
                     input logic [14:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // gap: 0 = no enable gaps, 1 = random gaps
  task automatic encode(input logic [6:0] m, input bit gap);
    int n = 0;
    logic [14:0] e = ref_cw(m);
    @(negedge clk_i);
    rst_ni = 1'b0; en_i = 1'b0; msg_i = $urandom;
    @(negedge clk_i);
    chk(hold_o == 1'b0 && cw_o == '0, "R1", {hold_o, cw_o[13:0]}, '0);
    rst_ni = 1'b1;
    while (n < 15) begin
      en_i  = gap ? ($urandom_range(0, 2) != 0) : 1'b1;
      msg_i = (n == 0) ? m : 7'($urandom);  // R6 scramble after capture
      @(negedge clk_i);
      if (en_i) n++;
      if (n < 15) begin
        chk(hold_o == 1'b0, n == 0 ? "R3" : "R2", 15'(hold_o), 15'd0);
        chk(cw_o == '0, "R8", cw_o, '0);
      end
    end
    chk(hold_o == 1'b1, "R2", 15'(hold_o), 15'd1);
    chk(cw_o == e, (m == 0) ? "R9" : "R4", cw_o, e);
    for (int k = 0; k < 3; k++) begin
      en_i = 1'($urandom); msg_i = 7'($urandom);
      @(negedge clk_i);
      chk(hold_o == 1'b1 && cw_o == e, "R7 R6", cw_o, e);
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0b1c));
    // R1 R8: reset state
    #1;
    chk(hold_o == 1'b0 && cw_o == '0, "R1", cw_o, '0);
    // R9 directed zero message, R4 all-ones
    encode(7'h00, 1'b0);
    encode(7'h7F, 1'b0);
    encode(7'h40, 1'b1);
    encode(7'h01, 1'b1);
    // R4 R5 full sweep, alternating enable gaps (R3)
    for (int i = 0; i < 128; i++) encode(7'(i), 1'(i & 1));
    for (int i = 0; i < 100; i++) encode(7'($urandom), 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule